// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block performs the four BCD correction operations of an 8-bit x86-style ALU: decimal adjust after addition or subtraction, and ASCII adjust after addition or subtraction. It receives the low and high accumulator bytes with the incoming carry and half-carry flags, an operation code and a core-generation select. It returns the corrected accumulator bytes and a complete set of arithmetic flags. Instruction decode, flag storage and instruction timing belong to the surrounding datapath.

Two core generations are supported, selected per operation. The later generation bases its decimal corrections on the original accumulator and carry, and its ASCII corrections propagate through the full 16-bit accumulator. The early generation bases its decimal high correction on the partly corrected byte, with a threshold that depends on the half-carry input. Its ASCII corrections touch only the low byte before stepping the high byte, and it reports signed overflow of the last correction step. A parameter selects whether the result leaves through a register stage or straight from the combinational logic.

Top module: `dadj_unit`

## Requirements
- R1: Operation codes on `op_in` are 0 = decimal add adjust, 1 = decimal subtract adjust, 2 = ASCII add adjust, 3 = ASCII subtract adjust. `core_in` = 0 selects the early core and 1 selects the later core. Decimal operations return `ah_out` equal to `ah_in`.
- R2: For decimal operations the low correction (plus or minus 6 on AL) applies when AL[3:0] > 9 or `af_in` is 1. `af_out` is 1 exactly when it applies.
- R3: Later core, decimal operations: the high correction (plus or minus 0x60) applies when the original AL > 0x99 or `cf_in` is 1. `cf_out` is 1 exactly when it applies.
- R4: Early core, decimal operations: the high correction applies when the partly corrected AL exceeds 0x9F (if `af_in` was 1) or 0x99 (if `af_in` was 0), or when `cf_in` is 1, or when the low step carried or borrowed out of bit 7. `cf_out` is 1 exactly when it applies.
- R5: `zf_out` is 1 when the final AL is 0. `sf_out` equals final AL[7]. `pf_out` is 1 when the final AL has an even number of one bits.
- R6: Later core, ASCII operations with the correction condition (AL[3:0] > 9 or `af_in`): AX = {AH,AL} is moved by plus or minus 6 as a 16-bit value, then AH is moved by plus or minus 1. `cf_out` and `af_out` are both 1.
- R7: Early core, ASCII operations with the correction condition: only AL is moved by plus or minus 6, and AH is moved by plus or minus 1 with no carry or borrow from AL. `cf_out` and `af_out` are both 1.
- R8: ASCII operations always clear AL[7:4]. Without the correction condition, AL[3:0] and AH pass unchanged and `cf_out` and `af_out` are 0.
- R9: Early core: `of_out` is the signed overflow of the last correction step applied, and 0 when no step applied. Later core: `of_out` is 0.
- R10: With `OUT_REG` = 1, results appear one clock after `in_valid`, and `out_valid` follows `in_valid` with the same one-cycle delay. Reset clears `out_valid` and all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op_in | input | 2 | Operation code (see R1) |
| core_in | input | 1 | Core generation: 0 early, 1 later |
| al_in | input | 8 | Accumulator low byte |
| ah_in | input | 8 | Accumulator high byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming half-carry flag |
| out_valid | output | 1 | Result valid |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry flag result |
| af_out | output | 1 | Half-carry flag result |
| zf_out | output | 1 | Zero flag result |
| sf_out | output | 1 | Sign flag result |
| pf_out | output | 1 | Parity flag result |
| of_out | output | 1 | Overflow flag result |

## Verification
The bench sweeps every AL value against every carry/half-carry pair, every operation and both cores, so every threshold edge is covered. These edges include 0x99 against 0x9A, the 0x9F threshold of the early core, and low bytes that wrap through 0xFA or below 0x06. A design that compared the corrected byte where the original belongs, or that used a single threshold, would give a wrong carry and byte at AL values between 0x9A and 0x9F. A design that carried from AL into AH in the wrong core would give an AH that is off by one near AL 0xFA and AL below 6. Directed cases with AH at 0xFF and 0x00 expose missing wrap handling.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

   typedef enum logic [1:0] {
      OP_DEC_ADD = 2'd0,
      OP_DEC_SUB = 2'd1,
      OP_ASC_ADD = 2'd2,
      OP_ASC_SUB = 2'd3
   } adj_op_e;

   typedef enum logic {
      CORE_EARLY = 1'b0,
      CORE_LATER = 1'b1
   } core_gen_e;

   // partial result from one adjust path, before status flags
   typedef struct packed {
      logic [7:0] al;
      logic [7:0] ah;
      logic       cf;
      logic       af;
      logic       of;
   } adj_res_t;

   // full result presented at the block edge
   typedef struct packed {
      logic [7:0] al;
      logic [7:0] ah;
      logic       cf;
      logic       af;
      logic       zf;
      logic       sf;
      logic       pf;
      logic       of;
   } adj_out_t;

   // operation attributes carried beside the result
   typedef struct packed {
      adj_op_e    op;
      core_gen_e  core;
      logic [7:0] ah;
   } adj_meta_t;

   function automatic logic ovf_add8(logic [7:0] a, logic [7:0] b, logic [7:0] r);
      return (a[7] == b[7]) && (r[7] != a[7]);
   endfunction

   function automatic logic ovf_sub8(logic [7:0] a, logic [7:0] b, logic [7:0] r);
      return (a[7] != b[7]) && (r[7] != a[7]);
   endfunction

endpackage

// File: rtl/dadj_decimal.sv
module dadj_decimal
   import dadj_pkg::*;
#(
   parameter int LO_LIMIT    = 9,
   parameter int HI_LIMIT    = 8'h99,
   parameter int HI_LIMIT_AF = 8'h9F,
   parameter int ADJ_LO      = 6
) (
   input  logic [7:0] al_in,
   input  logic [7:0] ah_in,
   input  logic       cf_in,
   input  logic       af_in,
   input  logic       is_sub,
   input  core_gen_e  core,
   output adj_res_t   res
);
   localparam logic [3:0] LO_LIM4  = 4'(LO_LIMIT);
   localparam logic [7:0] HI_LIM8  = 8'(HI_LIMIT);
   localparam logic [7:0] HI_AF8   = 8'(HI_LIMIT_AF);
   localparam logic [7:0] ADJ_LO8  = 8'(ADJ_LO);
   localparam logic [7:0] ADJ_HI8  = 8'(ADJ_LO * 16);

   logic       lo_hit;
   logic [8:0] lo_sum;
   logic       lo_cy;
   logic [7:0] part;
   logic [7:0] thr;
   logic [7:0] cmp_val;
   logic       cy_seen;
   logic       hi_hit;
   logic [7:0] fin;
   logic       lo_ovf;
   logic       hi_ovf;

   always_comb begin
      lo_hit  = (al_in[3:0] > LO_LIM4) || af_in;
      lo_sum  = is_sub ? ({1'b0, al_in} - {1'b0, ADJ_LO8})
                       : ({1'b0, al_in} + {1'b0, ADJ_LO8});
      lo_cy   = lo_hit && lo_sum[8];
      part    = lo_hit ? lo_sum[7:0] : al_in;
      lo_ovf  = is_sub ? ovf_sub8(al_in, ADJ_LO8, lo_sum[7:0])
                       : ovf_add8(al_in, ADJ_LO8, lo_sum[7:0]);

      // early core looks at the partly corrected byte, later core at the original
      if (core == CORE_EARLY) begin
         thr     = af_in ? HI_AF8 : HI_LIM8;
         cmp_val = part;
         cy_seen = cf_in || lo_cy;
      end else begin
         thr     = HI_LIM8;
         cmp_val = al_in;
         cy_seen = cf_in;
      end
      hi_hit = (cmp_val > thr) || cy_seen;

      fin    = hi_hit ? (is_sub ? part - ADJ_HI8 : part + ADJ_HI8) : part;
      hi_ovf = is_sub ? ovf_sub8(part, ADJ_HI8, fin) : ovf_add8(part, ADJ_HI8, fin);

      res.al = fin;
      res.ah = ah_in;
      res.cf = hi_hit;
      res.af = lo_hit;
      if (core == CORE_EARLY)
         res.of = hi_hit ? hi_ovf : (lo_hit && lo_ovf);
      else
         res.of = 1'b0;
   end
endmodule

// File: rtl/dadj_ascii.sv
module dadj_ascii
   import dadj_pkg::*;
#(
   parameter int LO_LIMIT = 9,
   parameter int ADJ_LO   = 6
) (
   input  logic [7:0] al_in,
   input  logic [7:0] ah_in,
   input  logic       af_in,
   input  logic       is_sub,
   input  core_gen_e  core,
   output adj_res_t   res
);
   localparam logic [3:0] LO_LIM4 = 4'(LO_LIMIT);
   localparam logic [7:0] ADJ_LO8 = 8'(ADJ_LO);

   logic       hit;
   logic [8:0] sum9;
   logic [7:0] ah_step;
   logic [7:0] ah_wide;

   always_comb begin
      hit  = (al_in[3:0] > LO_LIM4) || af_in;
      sum9 = is_sub ? ({1'b0, al_in} - {1'b0, ADJ_LO8})
                    : ({1'b0, al_in} + {1'b0, ADJ_LO8});

      // early core: high byte stepped alone
      ah_step = is_sub ? ah_in - 8'd1 : ah_in + 8'd1;
      // later core: bit 8 of the low sum is the carry or borrow into AH
      ah_wide = is_sub ? ah_step - {7'd0, sum9[8]} : ah_step + {7'd0, sum9[8]};

      res.ah = ah_in;
      res.al = {4'h0, al_in[3:0]};
      res.cf = 1'b0;
      res.af = 1'b0;
      res.of = 1'b0;
      if (hit) begin
         res.al = {4'h0, sum9[3:0]};
         res.ah = (core == CORE_LATER) ? ah_wide : ah_step;
         res.cf = 1'b1;
         res.af = 1'b1;
         if (core == CORE_EARLY)
            res.of = is_sub ? ovf_sub8(al_in, ADJ_LO8, sum9[7:0])
                            : ovf_add8(al_in, ADJ_LO8, sum9[7:0]);
      end
   end
endmodule

// File: rtl/dadj_flags.sv
module dadj_flags
   import dadj_pkg::*;
(
   input  adj_res_t res,
   output adj_out_t flagged
);
   always_comb begin
      flagged.al = res.al;
      flagged.ah = res.ah;
      flagged.cf = res.cf;
      flagged.af = res.af;
      flagged.of = res.of;
      flagged.zf = (res.al == 8'h00);
      flagged.sf = res.al[7];
      flagged.pf = ~(^res.al);
   end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
   import dadj_pkg::*;
#(
   parameter int OUT_REG     = 1,
   parameter int LO_LIMIT    = 9,
   parameter int HI_LIMIT    = 8'h99,
   parameter int HI_LIMIT_AF = 8'h9F,
   parameter int ADJ_LO      = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [1:0] op_in,
   input  logic       core_in,
   input  logic [7:0] al_in,
   input  logic [7:0] ah_in,
   input  logic       cf_in,
   input  logic       af_in,
   output logic       out_valid,
   output logic [7:0] al_out,
   output logic [7:0] ah_out,
   output logic       cf_out,
   output logic       af_out,
   output logic       zf_out,
   output logic       sf_out,
   output logic       pf_out,
   output logic       of_out
);
   // elaboration-time parameter checks
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("OUT_REG must be 0 or 1");
   end
   if (LO_LIMIT < 0 || LO_LIMIT > 15) begin : g_bad_lolim
      $error("LO_LIMIT must fit a nibble");
   end
   if (HI_LIMIT < 0 || HI_LIMIT > 255 || HI_LIMIT_AF < HI_LIMIT || HI_LIMIT_AF > 255) begin : g_bad_hilim
      $error("high thresholds must fit a byte with HI_LIMIT_AF >= HI_LIMIT");
   end
   if (ADJ_LO < 1 || ADJ_LO > 15) begin : g_bad_adj
      $error("ADJ_LO must be a nonzero nibble");
   end

   adj_op_e   op_e;
   core_gen_e core_e;
   logic      is_sub;
   adj_res_t  dec_res;
   adj_res_t  asc_res;
   adj_res_t  sel_res;
   adj_out_t  comb_out;
   adj_meta_t comb_meta;
   adj_out_t  res_o;
   adj_meta_t meta_o;
   logic      vld_o;

   assign op_e   = adj_op_e'(op_in);
   assign core_e = core_gen_e'(core_in);
   assign is_sub = op_in[0];

   dadj_decimal #(
      .LO_LIMIT   (LO_LIMIT),
      .HI_LIMIT   (HI_LIMIT),
      .HI_LIMIT_AF(HI_LIMIT_AF),
      .ADJ_LO     (ADJ_LO)
   ) u_decimal (
      .al_in (al_in),
      .ah_in (ah_in),
      .cf_in (cf_in),
      .af_in (af_in),
      .is_sub(is_sub),
      .core  (core_e),
      .res   (dec_res)
   );

   dadj_ascii #(
      .LO_LIMIT(LO_LIMIT),
      .ADJ_LO  (ADJ_LO)
   ) u_ascii (
      .al_in (al_in),
      .ah_in (ah_in),
      .af_in (af_in),
      .is_sub(is_sub),
      .core  (core_e),
      .res   (asc_res)
   );

   assign sel_res = op_in[1] ? asc_res : dec_res;

   dadj_flags u_flags (
      .res    (sel_res),
      .flagged(comb_out)
   );

   always_comb begin
      comb_meta.op   = op_e;
      comb_meta.core = core_e;
      comb_meta.ah   = ah_in;
   end

   if (OUT_REG == 1) begin : g_reg
      adj_out_t  res_q;
      adj_meta_t meta_q;
      logic      vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q  <= '0;
            meta_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               res_q  <= comb_out;
               meta_q <= comb_meta;
            end
         end
      end
      assign res_o  = res_q;
      assign meta_o = meta_q;
      assign vld_o  = vld_q;

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (out_valid == $past(in_valid))) else $error("valid latency");  // R10
   end else begin : g_comb
      assign res_o  = comb_out;
      assign meta_o = comb_meta;
      assign vld_o  = in_valid;
   end

   assign out_valid = vld_o;
   assign al_out    = res_o.al;
   assign ah_out    = res_o.ah;
   assign cf_out    = res_o.cf;
   assign af_out    = res_o.af;
   assign zf_out    = res_o.zf;
   assign sf_out    = res_o.sf;
   assign pf_out    = res_o.pf;
   assign of_out    = res_o.of;

   AST_DEC_AH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !meta_o.op[1]) |-> (ah_out == meta_o.ah)) else $error("decimal AH");  // R1
   AST_ASCII_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && meta_o.op[1]) |-> (al_out[7:4] == 4'h0)) else $error("ascii nibble");  // R8
   AST_ASCII_CF_AF: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && meta_o.op[1]) |-> (cf_out == af_out)) else $error("ascii cf/af");  // R6
   AST_LATER_NO_OF: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && meta_o.core == CORE_LATER) |-> !of_out) else $error("later-core OF");  // R9
   AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((zf_out == (al_out == 8'h00)) && (sf_out == al_out[7]))) else $error("zf/sf");  // R5
   AST_ASCII_AH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && meta_o.op[1] && !cf_out) |-> (ah_out == meta_o.ah)) else $error("ascii AH");  // R8
endmodule

// File: tb/test_dadj_unit.sv
module test_dadj_unit;

   typedef struct {
      logic [7:0] al;
      logic [7:0] ah;
      logic       cf;
      logic       af;
      logic       zf;
      logic       sf;
      logic       pf;
      logic       of;
      int         op;
      int         core;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] op_in = 2'd0;
   logic       core_in = 1'b0;
   logic [7:0] al_in = 8'd0;
   logic [7:0] ah_in = 8'd0;
   logic       cf_in = 1'b0;
   logic       af_in = 1'b0;
   logic       out_valid;
   logic [7:0] al_out;
   logic [7:0] ah_out;
   logic       cf_out;
   logic       af_out;
   logic       zf_out;
   logic       sf_out;
   logic       pf_out;
   logic       of_out;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   reported = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   dadj_unit i_dadj_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op_in    (op_in),
      .core_in  (core_in),
      .al_in    (al_in),
      .ah_in    (ah_in),
      .cf_in    (cf_in),
      .af_in    (af_in),
      .out_valid(out_valid),
      .al_out   (al_out),
      .ah_out   (ah_out),
      .cf_out   (cf_out),
      .af_out   (af_out),
      .zf_out   (zf_out),
      .sf_out   (sf_out),
      .pf_out   (pf_out),
      .of_out   (of_out)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
      $finish;
   endtask

   function automatic int sgn8(int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   function automatic bit ovf8(int a, int b, int sub);
      int s;
      s = sub ? sgn8(a) - sgn8(b) : sgn8(a) + sgn8(b);
      return (s > 127) || (s < -128);
   endfunction

   // reference model written from the requirements
   function automatic exp_t model(int op, int core, int al, int ah, int cf, int af);
      exp_t e;
      int   sub;
      bit   lo;
      int   p;
      bit   lc;
      bit   hi;
      int   f;
      int   ax;
      sub = op % 2;
      lo  = ((al % 16) > 9) || (af != 0);
      e.op = op;
      e.core = core;
      e.of = 0;
      if (op < 2) begin
         p  = al;
         lc = 0;
         if (lo) begin
            p  = sub ? al - 6 : al + 6;
            lc = (p < 0) || (p > 255);
            p  = p & 255;
         end
         if (core == 1) hi = (al > 153) || (cf != 0);
         else           hi = (p > (af != 0 ? 159 : 153)) || (cf != 0) || lc;
         f = hi ? ((sub ? p - 96 : p + 96) & 255) : p;
         if (core == 0) e.of = hi ? ovf8(p, 96, sub) : (lo ? ovf8(al, 6, sub) : 1'b0);
         e.al = 8'(f);
         e.ah = 8'(ah);
         e.cf = hi;
         e.af = lo;
      end else begin
         if (lo) begin
            if (core == 1) begin
               ax = ah * 256 + al;
               ax = (sub ? ax - 6 : ax + 6) & 65535;
               e.ah = 8'(((ax / 256) + (sub ? -1 : 1)) & 255);
               e.al = 8'(ax % 16);
            end else begin
               e.al = 8'(((sub ? al - 6 : al + 6) & 255) % 16);
               e.ah = 8'((ah + (sub ? -1 : 1)) & 255);
               e.of = ovf8(al, 6, sub);
            end
            e.cf = 1;
            e.af = 1;
         end else begin
            e.al = 8'(al % 16);
            e.ah = 8'(ah);
            e.cf = 0;
            e.af = 0;
         end
      end
      e.zf = (e.al == 8'h00);
      e.sf = e.al[7];
      e.pf = ($countones(e.al) % 2) == 0;
      return e;
   endfunction

   task automatic drive(int op, int core, int al, int ah, int cf, int af);
      @(negedge clk);
      in_valid = 1'b1;
      op_in    = 2'(op);
      core_in  = 1'(core);
      al_in    = 8'(al);
      ah_in    = 8'(ah);
      cf_in    = 1'(cf);
      af_in    = 1'(af);
      sb.push_back(model(op, core, al, ah, cf, af));
   endtask

   // monitor / scoreboard
   initial begin
      exp_t  e;
      string rl;
      string rc;
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               chk("R10", "unexpected out_valid", 1, 0);
            end else begin
               e = sb.pop_front();
               if (e.op < 2) begin
                  rl = (e.core == 1) ? "R3" : "R4";
                  rc = rl;
                  chk("R1", "ah_out decimal", ah_out, e.ah);
                  chk("R2", "af_out decimal", af_out, e.af);
               end else begin
                  rl = e.cf ? ((e.core == 1) ? "R6" : "R7") : "R8";
                  rc = e.cf ? rl : "R8";
                  chk(rl, "ah_out ascii", ah_out, e.ah);
                  chk(rc, "af_out ascii", af_out, e.af);
               end
               chk(rl, "al_out", al_out, e.al);
               chk(rc, "cf_out", cf_out, e.cf);
               chk("R5", "zf_out", zf_out, e.zf);
               chk("R5", "sf_out", sf_out, e.sf);
               chk("R5", "pf_out", pf_out, e.pf);
               chk("R9", "of_out", of_out, e.of);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      chk("R10", "watchdog expired", 1, 0);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "out_valid in reset", out_valid, 0);
      chk("R10", "al_out in reset", al_out, 0);
      chk("R10", "cf_out in reset", cf_out, 0);
      chk("R10", "zf_out in reset", zf_out, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "out_valid idle after reset", out_valid, 0);

      // directed corners: AH wrap, thresholds
      drive(2, 1, 8'hFA, 8'hFF, 0, 0);  // R6 carry into AH
      drive(2, 0, 8'hFA, 8'hFF, 0, 0);  // R7 no carry into AH
      drive(3, 1, 8'h03, 8'h00, 0, 1);  // R6 borrow from AH
      drive(3, 0, 8'h03, 8'h00, 0, 1);  // R7
      drive(0, 1, 8'h9A, 8'h11, 0, 0);  // R3
      drive(0, 0, 8'h99, 8'h22, 0, 1);  // R4 0x9F threshold
      drive(0, 1, 8'h99, 8'h22, 0, 1);  // R3
      drive(1, 0, 8'h00, 8'h33, 0, 1);  // R4 borrow out of low step
      drive(2, 0, 8'h35, 8'h44, 0, 0);  // R8 no adjust

      // exhaustive sweep
      for (int core = 0; core < 2; core++)
         for (int op = 0; op < 4; op++)
            for (int fl = 0; fl < 4; fl++)
               for (int al = 0; al < 256; al++)
                  drive(op, core, al, (al * 7 + op * 37 + fl * 91 + core * 128) & 255, fl / 2, fl % 2);

      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10", "scoreboard drained", sb.size(), 0);
      chk("R10", "out_valid low after stream", out_valid, 0);
      summary();
   end

endmodule